// File: doc/BRIEF.md
# Independent Watchdog Timer

This block is a free-running safety timer. It keeps a 12-bit down counter that is paced by a slow tick enable and a programmable prescaler. If software stops feeding it, the counter reaches zero and the block raises a system-reset pulse. The slow clock is modelled as a single-cycle `tick_i` enable in the host clock domain. Each tick also marks the moment when a pending configuration value moves into the counting logic.

Software uses a small write port and a read port. A key register accepts command words: one starts the timer, one feeds it, and one unlocks the two configuration registers. Every other key word locks them again. The prescaler register holds a 3-bit divide code and the reload register holds a 12-bit feed value. Each of the two has a busy flag, which stays set until the next tick has applied the new value. A strap input can start the timer straight out of reset with no software action. Once the timer is running, only an external reset or its own timeout stops it.

Top module: `wdg_top`

## Requirements
- R1: After reset, `sys_rst_o` is low, the prescaler reads 0, the reload reads 0xFFF, the status reads 0 and the timer is idle, so no reset pulse appears without a start.
- R2: Address 0 is the key register. Writing 0x5555 unlocks the configuration registers, and writing any other key value locks them. A write to a locked prescaler or reload register leaves its readback unchanged.
- R3: Address 1 reads back the prescaler code in bits [2:0] and address 2 reads back the reload value in bits [11:0]. The readback shows the last value accepted. Address 0 reads 0.
- R4: Address 3 is the status register. Bit 0 is prescaler-busy and bit 1 is reload-busy. A busy flag is set from the cycle after an accepted write. It clears on the first `tick_i` after that write, which is when the value is applied.
- R5: Writing key 0xCCCC while idle starts the timer with the counter at 0xFFF. The counter then drops by one on each prescaled tick.
- R6: Writing key 0xAAAA while running loads the counter from the applied reload value, so a timer that is fed often enough never times out.
- R7: Prescaler code n (0..6) divides `tick_i` by 4·2^n. Code 7 divides by 256.
- R8: When a running counter holds 0, `sys_rst_o` rises one cycle later and stays high until the second `tick_i` after it rose, which covers at least one full tick period. The timer is then idle and gives no further pulse.
- R9: If `hw_start_i` is high in the first cycle after reset is released, the timer starts from 0xFFF at the default prescaler. If it is low, the timer stays idle.
- R10: While the timer is running, no key value stops it: writes of 0x5555, 0x0000 or 0xCCCC do not prevent the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle enable per slow-clock period |
| hw_start_i | input | 1 | Strap that starts the timer out of reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address (0 key, 1 prescaler, 2 reload, 3 status) |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 16 | Read data, combinational from `rd_addr_i` |
| sys_rst_o | output | 1 | Registered system-reset pulse |

## Verification
The assertions assume that `tick_i` is a clean one-cycle enable that is synchronous to `clk_i`, and that at most one register write arrives per cycle. The bench drives `tick_i` from a phase counter with periods of 1, 5 and 8 cycles, so every tick lasts exactly one cycle. Its writes are single-cycle strobes separated by idle cycles. The prescaler-update rule allows the counter value to exceed a newly shrunk divider, so no assertion bounds the prescaler count. The bench changes the divide code only while the timer is idle.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int KW     = 16;
  localparam int AW     = 2;
  localparam int CW     = 12;
  localparam int PW     = 3;
  localparam int MAX_SH = 6;

  localparam logic [KW-1:0] KEY_START  = 16'hCCCC;
  localparam logic [KW-1:0] KEY_FEED   = 16'hAAAA;
  localparam logic [KW-1:0] KEY_UNLOCK = 16'h5555;

  localparam logic [AW-1:0] A_KEY    = 2'd0;
  localparam logic [AW-1:0] A_PRESC  = 2'd1;
  localparam logic [AW-1:0] A_RELOAD = 2'd2;
  localparam logic [AW-1:0] A_STAT   = 2'd3;
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [KW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [KW-1:0] rd_data_o,
  output logic          start_o,
  output logic          feed_o,
  output logic [PW-1:0] presc_o,
  output logic [CW-1:0] reload_o
);
  logic          wa_q;
  logic [PW-1:0] presc_sh_q, presc_act_q;
  logic [CW-1:0] rl_sh_q, rl_act_q;
  logic          pbusy_q, rbusy_q;
  logic          key_wr, presc_wr, rl_wr;

  assign key_wr   = wr_en_i && (wr_addr_i == A_KEY);
  assign presc_wr = wr_en_i && (wr_addr_i == A_PRESC) && wa_q;
  assign rl_wr    = wr_en_i && (wr_addr_i == A_RELOAD) && wa_q;
  assign start_o  = key_wr && (wr_data_i == KEY_START);
  assign feed_o   = key_wr && (wr_data_i == KEY_FEED);
  assign presc_o  = presc_act_q;
  assign reload_o = rl_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wa_q <= 1'b0;
    else if (key_wr) wa_q <= (wr_data_i == KEY_UNLOCK);
  end

  // shadow takes the write, active copy follows on the next slow tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_sh_q  <= '0;
      presc_act_q <= '0;
      pbusy_q     <= 1'b0;
    end else if (presc_wr) begin
      presc_sh_q <= wr_data_i[PW-1:0];
      pbusy_q    <= 1'b1;
    end else if (tick_i && pbusy_q) begin
      presc_act_q <= presc_sh_q;
      pbusy_q     <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rl_sh_q  <= '1;
      rl_act_q <= '1;
      rbusy_q  <= 1'b0;
    end else if (rl_wr) begin
      rl_sh_q <= wr_data_i[CW-1:0];
      rbusy_q <= 1'b1;
    end else if (tick_i && rbusy_q) begin
      rl_act_q <= rl_sh_q;
      rbusy_q  <= 1'b0;
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      A_PRESC:  rd_data_o = {{(KW-PW){1'b0}}, presc_sh_q};
      A_RELOAD: rd_data_o = {{(KW-CW){1'b0}}, rl_sh_q};
      A_STAT:   rd_data_o = {{(KW-2){1'b0}}, rbusy_q, pbusy_q};
      default:  rd_data_o = '0;
    endcase
  end

  a_r2_presc_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_PRESC && !wa_q) |=> $stable(presc_sh_q));
  a_r2_reload_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_RELOAD && !wa_q) |=> $stable(rl_sh_q));
  a_r4_busy_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    presc_wr |=> pbusy_q);
  a_r4_busy_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && rbusy_q && !rl_wr) |=> !rbusy_q);
endmodule

// File: rtl/wdg_presc.sv
module wdg_presc
  import wdg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          run_i,
  input  logic [PW-1:0] code_i,
  output logic          ptick_o
);
  localparam int PCW = MAX_SH + 2;

  logic [PCW-1:0] pcnt_q;
  logic [PW-1:0]  sh;
  logic [PCW:0]   div;
  logic [PCW-1:0] div_m1;

  always_comb begin
    sh     = (code_i > PW'(MAX_SH)) ? PW'(MAX_SH) : code_i;
    div    = (PCW+1)'(4) << sh;
    div_m1 = PCW'(div - 1'b1);
  end

  // >= keeps a shrunk divider from stalling the count
  assign ptick_o = run_i && tick_i && (pcnt_q >= div_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pcnt_q <= '0;
    else if (!run_i) pcnt_q <= '0;
    else if (tick_i) pcnt_q <= ptick_o ? '0 : pcnt_q + 1'b1;
  end
endmodule

// File: rtl/wdg_core.sv
module wdg_core
  import wdg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          hw_start_i,
  input  logic          start_i,
  input  logic          feed_i,
  input  logic          ptick_i,
  input  logic [CW-1:0] reload_i,
  output logic          run_o,
  output logic          sys_rst_o
);
  logic          first_q, run_q, rst_q, rcnt_q;
  logic [CW-1:0] cnt_q;
  logic          fire, go;

  assign fire      = run_q && (cnt_q == '0);
  assign go        = (first_q && hw_start_i) || start_i;
  assign run_o     = run_q;
  assign sys_rst_o = rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) first_q <= 1'b1;
    else first_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '1;
    end else if (fire) begin
      run_q <= 1'b0;
      cnt_q <= '1;
    end else if (!run_q) begin
      if (go && !rst_q) begin
        run_q <= 1'b1;
        cnt_q <= '1;
      end
    end else if (feed_i) begin
      cnt_q <= reload_i;
    end else if (ptick_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // pulse ends on the second slow tick after it rises
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q  <= 1'b0;
      rcnt_q <= 1'b0;
    end else if (fire) begin
      rst_q  <= 1'b1;
      rcnt_q <= 1'b0;
    end else if (rst_q && tick_i) begin
      if (rcnt_q) rst_q <= 1'b0;
      rcnt_q <= 1'b1;
    end
  end

  a_r5_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && ptick_i && !feed_i && cnt_q != '0) |=>
      (cnt_q == $past(cnt_q) - {{(CW-1){1'b0}}, 1'b1}));
  a_r8_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_q == '0) |=> (rst_q && !run_q));
  a_r10_no_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_q != '0) |=> run_q);
  a_r8_idle_in_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |-> !run_q);
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          hw_start_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [KW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [KW-1:0] rd_data_o,
  output logic          sys_rst_o
);
  logic          start, feed, ptick, run;
  logic [PW-1:0] presc;
  logic [CW-1:0] reload;

  wdg_regs u_regs (
    .clk_i, .rst_ni, .tick_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_addr_i, .rd_data_o,
    .start_o(start), .feed_o(feed), .presc_o(presc), .reload_o(reload)
  );

  wdg_presc u_presc (
    .clk_i, .rst_ni, .tick_i, .run_i(run), .code_i(presc), .ptick_o(ptick)
  );

  wdg_core u_core (
    .clk_i, .rst_ni, .tick_i, .hw_start_i,
    .start_i(start), .feed_i(feed), .ptick_i(ptick), .reload_i(reload),
    .run_o(run), .sys_rst_o
  );
endmodule

// File: tb/sim_wdg_top.sv
module sim_wdg_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        hw_start_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [1:0]  rd_addr_i = '0;
  logic [15:0] rd_data_o;
  logic        sys_rst_o;

  int vectors = 0, errors = 0, cycles = 0, tick_per = 1, tph = 0;

  wdg_top u0 (.clk_i(clk), .rst_ni, .tick_i, .hw_start_i, .wr_en_i, .wr_addr_i,
              .wr_data_i, .rd_addr_i, .rd_data_o, .sys_rst_o);

  always #2 clk = ~clk;

  always @(posedge clk) begin
    #1;
    if (tick_per <= 1) tick_i = 1'b1;
    else begin
      tick_i = (tph == 0);
      tph = (tph + 1) % tick_per;
    end
  end

  // behavioural reference model
  int m_wa, m_psh, m_pa, m_pb, m_rsh, m_ra, m_rb;
  int m_run, m_cnt, m_pcnt, m_rst, m_rc, m_first;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_wa = 0; m_psh = 0; m_pa = 0; m_pb = 0; m_rsh = 4095; m_ra = 4095; m_rb = 0;
      m_run = 0; m_cnt = 4095; m_pcnt = 0; m_rst = 0; m_rc = 0; m_first = 1;
    end else begin
      int divv, ptick, fire, key, start, feed, pwr, rwr;
      divv  = 4 << ((m_pa > 6) ? 6 : m_pa);
      ptick = m_run && tick_i && (m_pcnt >= divv - 1);
      fire  = m_run && (m_cnt == 0);
      key   = wr_en_i && (wr_addr_i == 0);
      start = (key && wr_data_i == 16'hCCCC) || (m_first && hw_start_i);
      feed  = key && wr_data_i == 16'hAAAA;
      pwr   = wr_en_i && (wr_addr_i == 1) && m_wa;
      rwr   = wr_en_i && (wr_addr_i == 2) && m_wa;
      if (!m_run) m_pcnt = 0;
      else if (tick_i) m_pcnt = ptick ? 0 : m_pcnt + 1;
      if (fire) begin m_run = 0; m_cnt = 4095; m_rst = 1; m_rc = 0; end
      else begin
        if (m_rst && tick_i) begin if (m_rc) m_rst = 0; m_rc = 1; end
        if (!m_run) begin if (start && !m_rst) begin m_run = 1; m_cnt = 4095; end end
        else if (feed) m_cnt = m_ra;
        else if (ptick) m_cnt = m_cnt - 1;
      end
      if (pwr) begin m_psh = wr_data_i[2:0]; m_pb = 1; end
      else if (tick_i && m_pb) begin m_pa = m_psh; m_pb = 0; end
      if (rwr) begin m_rsh = wr_data_i[11:0]; m_rb = 1; end
      else if (tick_i && m_rb) begin m_ra = m_rsh; m_rb = 0; end
      if (key) m_wa = (wr_data_i == 16'h5555);
      m_first = 0;
    end
  end

  function automatic int m_read(input logic [1:0] a);
    case (a)
      2'd1: return m_psh;
      2'd2: return m_rsh;
      2'd3: return (m_rb << 1) | m_pb;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  always @(negedge clk) begin
    check("model rd_data", int'(rd_data_o), m_read(rd_addr_i));
    check("model sys_rst", int'(sys_rst_o), m_rst);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected under 190000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(posedge clk); #1;
    rd_addr_i = a;
    @(negedge clk);
    v = int'(rd_data_o);
  endtask

  task automatic do_reset(input logic hs);
    @(posedge clk); #1;
    rst_ni = 1'b0; hw_start_i = hs;
    idle(3);
    rst_ni = 1'b1;
  endtask

  task automatic wait_rise(input int maxc, output int n);
    n = 0;
    while (!sys_rst_o && n < maxc) begin @(negedge clk); n++; end
  endtask

  task automatic pulse_width(output int w);
    w = 0;
    while (sys_rst_o && w < 100) begin w++; @(negedge clk); end
  endtask

  initial begin
    int v, n, w;
    do_reset(1'b0);
    tick_per = 1;
    // R1 reset state
    rd(2'd1, v); check("R1 presc", v, 0);
    rd(2'd2, v); check("R1 reload", v, 12'hFFF);
    rd(2'd3, v); check("R1 status", v, 0);
    check("R1 sys_rst", int'(sys_rst_o), 0);
    rd(2'd0, v); check("R3 key reads zero", v, 0);

    // R2 locked writes ignored
    wr(2'd1, 16'h0005);
    rd(2'd1, v); check("R2 locked presc", v, 0);
    wr(2'd2, 16'h0123);
    rd(2'd2, v); check("R2 locked reload", v, 12'hFFF);

    // R3/R4 unlocked writes and busy flags with slow ticks
    tick_per = 8;
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'hFFFA);
    rd(2'd3, v); check("R4 presc busy", v & 1, 1);
    rd(2'd1, v); check("R3 presc field", v, 2);
    idle(10);
    rd(2'd3, v); check("R4 presc busy cleared", v, 0);
    wr(2'd2, 16'hF014);
    rd(2'd3, v); check("R4 reload busy", v, 2);
    rd(2'd2, v); check("R3 reload field", v, 12'h014);
    idle(10);
    rd(2'd3, v); check("R4 reload busy cleared", v, 0);
    wr(2'd0, 16'h1234);
    wr(2'd1, 16'h0006);
    rd(2'd1, v); check("R2 relocked presc", v, 2);

    // R5/R6/R10 feeding keeps it alive, then timeout at div 16 reload 20
    tick_per = 1;
    rd_addr_i = 2'd3;
    wr(2'd0, 16'hCCCC);
    for (int i = 0; i < 5; i++) begin
      idle(100);
      wr(2'd0, 16'hAAAA);
      check("R6 fed no reset", int'(sys_rst_o), 0);
    end
    wr(2'd0, 16'h5555);
    wr(2'd0, 16'h0000);
    wait_rise(600, n);
    check("R10 timeout after keys", int'(n >= 290 && n <= 330), 1);
    pulse_width(w);
    check("R8 width tick every cycle", w, 2);
    idle(1000);
    check("R8 idle after pulse", int'(sys_rst_o), 0);

    // R7 code 7 divides by 256
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'h0007);
    wr(2'd2, 16'h0002);
    idle(4);
    wr(2'd0, 16'hCCCC);
    wr(2'd0, 16'hAAAA);
    wait_rise(2000, n);
    check("R7 code7 timeout", int'(n >= 500 && n <= 780), 1);
    idle(20);

    // R7/R8 code 0 reload 0, slow ticks: pulse spans a tick period
    tick_per = 5;
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'h0000);
    idle(12);
    wr(2'd0, 16'hCCCC);
    wr(2'd0, 16'hAAAA);
    wait_rise(50, n);
    check("R7 reload zero fires", int'(n <= 5), 1);
    pulse_width(w);
    check("R8 width slow tick", int'(w >= 6 && w <= 10), 1);

    // R9 strap start
    tick_per = 1;
    do_reset(1'b1);
    wait_rise(17000, n);
    check("R9 strap timeout", int'(n >= 16370 && n <= 16400), 1);
    do_reset(1'b0);
    wait_rise(17000, n);
    check("R9 no strap idle", int'(sys_rst_o), 0);
    check("R5 idle without start", n, 17000);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule